// File: doc/BRIEF.md
# Single-Slot Synchronous Queue with Redundant Occupancy Flag

This block is a synchronous queue that holds exactly one word. Words enter through a valid/ready write port and leave through a valid/ready read port. One data register holds the word, so no address or pointer logic is needed. Occupancy is a single flag flop. A synchronous clear empties the queue, and a one-bit depth output reports whether a word is held.

When the `SECURE` parameter is 1, a second flop holds the complement of the occupancy flag. The integrity output is combinational. It rises whenever the two flops stop holding opposite values, for example after an upset or an injected fault, and it stays high while the mismatch lasts. When `SECURE` is 0, the complement flop is not built and the integrity output is held at 0.

The queue can pass one word per cycle. When the queue is full and the consumer takes the word, the write side is ready in that same cycle, and a new word can replace the old one.

Top module: `single_slot_fifo`

## Requirements
- R1: After reset, rvalid_o=0, depth_o=0, wready_o=1 and err_o=0.
- R2: A write accepted while the queue is empty stores wdata_i at that clock edge. From the next cycle, rvalid_o=1 and rdata_o shows the written word.
- R3: While full with rready_i=0, wready_o=0. A write offered in that state is ignored: rdata_o keeps the held word and rvalid_o stays 1.
- R4: While full with rready_i=1, wready_o=1. A write offered in that cycle replaces the held word, and the queue stays full.
- R5: A read accepted while full with no write empties the queue in the next cycle (rvalid_o=0).
- R6: depth_o is 1 when a word is held and 0 when the queue is empty, and it always equals rvalid_o.
- R7: clr_i=1 empties the queue at the next edge. It takes priority over a write offered in the same cycle.
- R8: With SECURE=1, err_o=1 in the same cycle that the flag and its complement copy hold equal values. It stays 1 while they are equal. The held word and rvalid_o are not affected.
- R9: With SECURE=0, err_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear |
| wvalid_i | input | 1 | Write request |
| wready_o | output | 1 | Write can be accepted |
| wdata_i | input | WIDTH | Write data |
| rvalid_o | output | 1 | Word available |
| rready_i | input | 1 | Consumer takes the word |
| rdata_o | output | WIDTH | Held word |
| depth_o | output | 1 | Occupancy, 0 or 1 |
| err_o | output | 1 | Occupancy integrity error |

## Verification
A corrupted occupancy flag shows up at the ports in the same cycle. rvalid_o and depth_o change together, and wready_o may be wrong against rready_i. A corrupted complement copy shows only on err_o, which rises in the same cycle as the corruption. The bench covers every combination of occupancy, write, read and clear, and then a long pseudo-random run against a one-word model. It forces each value onto the complement flop and checks that err_o responds and that the held data does not change.

// File: rtl/single_slot_fifo_pkg.sv
package single_slot_fifo_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clr;
  } slot_ctl_t;
endpackage

// File: rtl/single_slot_store.sv
module single_slot_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/single_slot_flag.sv
module single_slot_flag
  import single_slot_fifo_pkg::*;
#(
  parameter bit SECURE = 1'b1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  slot_ctl_t ctl_i,
  output logic      full_o,
  output logic      err_o
);
  logic full_q, full_d;

  always_comb begin
    full_d = full_q;
    if (ctl_i.clr)       full_d = 1'b0;
    else if (ctl_i.push) full_d = 1'b1;
    else if (ctl_i.pop)  full_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= full_d;
  end

  assign full_o = full_q;

  if (SECURE) begin : gen_secure
    logic inv_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) inv_q <= 1'b1;
      else         inv_q <= ~full_d;
    end
    // pair must always be complementary
    assign err_o = ~(full_q ^ inv_q);
  end else begin : gen_plain
    assign err_o = 1'b0;
  end
endmodule

// File: rtl/single_slot_fifo.sv
module single_slot_fifo
  import single_slot_fifo_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter bit SECURE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wvalid_i,
  output logic             wready_o,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             rvalid_o,
  input  logic             rready_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             depth_o,
  output logic             err_o
);
  logic      full;
  slot_ctl_t ctl;

  // full slot may be refilled in the cycle it drains
  assign wready_o = ~full | rready_i;
  assign ctl.push = wvalid_i & wready_o & ~clr_i;
  assign ctl.pop  = full & rready_i;
  assign ctl.clr  = clr_i;

  single_slot_flag #(.SECURE(SECURE)) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (ctl),
    .full_o (full),
    .err_o  (err_o)
  );

  single_slot_store #(.WIDTH(WIDTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (ctl.push),
    .d_i    (wdata_i),
    .q_o    (rdata_o)
  );

  assign rvalid_o = full;
  assign depth_o  = full;
endmodule

// File: rtl/single_slot_fifo_chk.sv
module single_slot_fifo_chk #(
  parameter int WIDTH  = 8,
  parameter bit SECURE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             wvalid_i,
  input logic             wready_o,
  input logic [WIDTH-1:0] wdata_i,
  input logic             rvalid_o,
  input logic             rready_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic             depth_o,
  input logic             err_o
);
  assert_fill_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_i && wready_o && !clr_i |=> rvalid_o && rdata_o == $past(wdata_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i && !clr_i |=> rvalid_o && $stable(rdata_o));

  assert_block_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && !rready_i |-> !wready_o);

  assert_drain_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o && rready_i && !wvalid_i && !clr_i |=> !rvalid_o);

  assert_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !rvalid_o && !depth_o);
endmodule

bind single_slot_fifo single_slot_fifo_chk #(.WIDTH(WIDTH), .SECURE(SECURE)) u_chk (.*);

// File: tb/single_slot_fifo_test.sv
module single_slot_fifo_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0, wv = 1'b0, rr = 1'b0;
  logic [W-1:0] wd = '0;
  logic wready_s, rvalid_s, depth_s, err_s;
  logic wready_p, rvalid_p, depth_p, err_p;
  logic [W-1:0] rdata_s, rdata_p;

  int checks = 0, errors = 0;
  logic exp_full = 1'b0;
  logic [W-1:0] exp_data = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  single_slot_fifo #(.WIDTH(W), .SECURE(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wvalid_i(wv), .wready_o(wready_s),
    .wdata_i(wd), .rvalid_o(rvalid_s), .rready_i(rr), .rdata_o(rdata_s),
    .depth_o(depth_s), .err_o(err_s));

  single_slot_fifo #(.WIDTH(W), .SECURE(1'b0)) uut_plain (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wvalid_i(wv), .wready_o(wready_p),
    .wdata_i(wd), .rvalid_o(rvalid_p), .rready_i(rr), .rdata_o(rdata_p),
    .depth_o(depth_p), .err_o(err_p));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // outputs that depend on state only; call just after a negedge
  task automatic chk_state(input string tag);
    chk({tag, " R6 rvalid"}, {31'b0, rvalid_s}, {31'b0, exp_full});
    chk({tag, " R6 depth"},  {31'b0, depth_s},  {31'b0, exp_full});
    chk({tag, " R9 plain rvalid"}, {31'b0, rvalid_p}, {31'b0, exp_full});
    chk({tag, " R9 err plain"}, {31'b0, err_p}, 32'd0);
    chk({tag, " R8 err quiet"}, {31'b0, err_s}, 32'd0);
    if (exp_full) begin
      chk({tag, " R2 rdata"}, {24'b0, rdata_s}, {24'b0, exp_data});
      chk({tag, " R2 plain rdata"}, {24'b0, rdata_p}, {24'b0, exp_data});
    end
  endtask

  task automatic step(input logic v, input logic r, input logic c, input logic [W-1:0] d,
                      input string tag);
    logic exp_wr;
    @(negedge clk);
    chk_state(tag);
    wv = v; rr = r; clr = c; wd = d;
    #1;
    exp_wr = !exp_full || r;
    chk({tag, exp_full ? (r ? " R4 wready" : " R3 wready") : " R2 wready"},
        {31'b0, wready_s}, {31'b0, exp_wr});
    chk({tag, " R9 plain wready"}, {31'b0, wready_p}, {31'b0, exp_wr});
    @(posedge clk);
    if (c)                  exp_full = 1'b0;           // R7
    else if (v && exp_wr) begin exp_full = 1'b1; exp_data = d; end
    else if (exp_full && r) exp_full = 1'b0;           // R5
  endtask

  task automatic set_state(input logic f);
    if (f) step(1'b1, 1'b1, 1'b0, 8'h5A, "setup");
    else   step(1'b0, 1'b0, 1'b1, 8'h00, "setup");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rvalid", {31'b0, rvalid_s}, 32'd0);
    chk("R1 depth", {31'b0, depth_s}, 32'd0);
    chk("R1 wready", {31'b0, wready_s}, 32'd1);
    chk("R1 err", {31'b0, err_s}, 32'd0);

    // every occupancy x write x read x clear combination
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 8; p++) begin
        set_state(s[0]);
        step(p[0], p[1], p[2], 8'(8'h10 + p + 8 * s), "sweep R3 R4 R5 R7");
      end
    end

    // pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      step(1'($urandom), 1'($urandom), ($urandom % 10) == 0, 8'($urandom), "random");
    end

    // fault on complement copy while full
    set_state(1'b1);
    @(negedge clk);
    wv = 1'b0; rr = 1'b0; clr = 1'b0;
    force uut.u_flag.gen_secure.inv_q = 1'b1;
    #1;
    chk("R8 err full", {31'b0, err_s}, 32'd1);
    chk("R8 data kept", {24'b0, rdata_s}, {24'b0, exp_data});
    @(negedge clk);
    chk("R8 err persists", {31'b0, err_s}, 32'd1);
    chk("R8 rvalid kept", {31'b0, rvalid_s}, 32'd1);
    chk("R8 data still kept", {24'b0, rdata_s}, {24'b0, exp_data});
    chk("R9 plain unaffected", {31'b0, err_p}, 32'd0);
    release uut.u_flag.gen_secure.inv_q;
    @(negedge clk);
    chk("R8 err clears", {31'b0, err_s}, 32'd0);

    // fault on complement copy while empty
    set_state(1'b0);
    @(negedge clk);
    wv = 1'b0; rr = 1'b0; clr = 1'b0;
    force uut.u_flag.gen_secure.inv_q = 1'b0;
    #1;
    chk("R8 err empty", {31'b0, err_s}, 32'd1);
    chk("R8 rvalid empty", {31'b0, rvalid_s}, 32'd0);
    release uut.u_flag.gen_secure.inv_q;
    @(negedge clk);
    chk("R8 err clears empty", {31'b0, err_s}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule